// File: doc/BRIEF.md
# Core Memory Gateway

The core memory gateway lets a host reach the instruction and data memories of six processing cores without a direct path into them. The host programs a small register window: it loads the word to store into a write-data register, then writes a command word holding the direction, a four-bit byte-lane mask and a 24-bit target address. That single command write launches one word transaction. The block decodes the address into a core number and a memory kind, checks whether the access is legal, performs it, and leaves any read result in a read-data register.

Instruction memory may only be touched while the shared core-control field says the cores are disabled; data memory is open in every core state. Illegal, unmapped or misaligned requests touch no storage and raise a sticky error flag instead. A status register shows a busy bit while a transaction is in flight and the error flag, which the host clears by writing a one to it.

The sequencer has five named states. IDLE waits for a command write (IDLE to CHECK). CHECK judges the decoded request and moves to XFER when it is legal or to FAULT when it is not. XFER performs the memory operation and returns to IDLE for a write or moves to FILL for a read. FILL places the masked read word in the read-data register and returns to IDLE. FAULT raises the error flag, zeroes the read-data register for a read, and returns to IDLE.

Top module: `core_mem_gateway`

## Requirements
- R1: After reset the status register (offset 0x10C) reads 0, the core-control field (offset 0x004, bits 1-0) reads 0 and the read-data register (offset 0x108) reads 0.
- R2: A host write to offset 0x100 while idle starts exactly one transaction; the command word uses bit 31 for direction (1 write, 0 read), bits 27-24 for the lane mask and bits 23-0 for the address. Status bit 0 (busy) is 1 from the cycle after the command write until the transaction ends, and a read finishes with busy low within four clock edges of the command write.
- R3: A command written while busy is ignored: it changes no memory and does not alter the transaction in flight.
- R4: Address bits 23-20 select core 0 to 5; core offset 0x8000-0xFFFF is that core's instruction memory and 0x10000-0x11FFF its data memory. Each core and each memory kind holds separate storage.
- R5: On a write, only byte lanes whose mask bit is set are changed; mask bit 3 selects data bits 31-24, bit 2 bits 23-16, bit 1 bits 15-8 and bit 0 bits 7-0 (big-endian lane order).
- R6: On a read, the read-data register receives the addressed word with every byte whose mask bit is clear forced to zero, using the lane order of R5.
- R7: Instruction memory is reachable only while the core-control field is 0 (disabled); codes 1 (enabled) and 2 (software reset) block it. Data memory is reachable under every core-control value.
- R8: An access to instruction memory while cores are not disabled, to a core number above 5, to an offset outside both windows, or to an address with bits 1-0 non-zero modifies no memory, sets status bit 1 (error), and for a read loads 0 into the read-data register.
- R9: The error bit stays set until the host writes status with bit 1 set; if such a clear arrives in the same cycle as a new fault is recorded, the error bit remains set.
- R10: The core-control field and the write-data register (offset 0x104) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host register write strobe |
| hw_addr | input | 12 | Host register write offset |
| hw_data | input | 32 | Host register write data |
| hr_addr | input | 12 | Host register read offset |
| hr_data | output | 32 | Host register read data (combinational) |

## Verification
Two functions can meet in one cycle: recording a fault and the host clearing the sticky error flag. The bench launches a read of instruction memory while the cores are enabled and times a status clear so that it is captured on the exact edge at which the sequencer sits in FAULT; the error bit must read 1 afterwards, and only a later, separate clear may drop it. A second collision, a command arriving while a write is still in flight, is provoked by issuing two command writes back to back and judged by reading back both target words.

// File: rtl/cmg_pkg.sv
package cmg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_XFER,
        ST_FILL,
        ST_FAULT
    } cmg_state_e;

    localparam logic [11:0] OFS_CORECTL = 12'h004;
    localparam logic [11:0] OFS_CMD     = 12'h100;
    localparam logic [11:0] OFS_WDATA   = 12'h104;
    localparam logic [11:0] OFS_RDATA   = 12'h108;
    localparam logic [11:0] OFS_STAT    = 12'h10C;

    localparam logic [1:0] CC_OFF  = 2'd0;
    localparam logic [1:0] CC_RUN  = 2'd1;
    localparam logic [1:0] CC_SRST = 2'd2;

    localparam int LANES     = 4;
    localparam int OFS_BITS  = 13;

endpackage

// File: rtl/cmg_addr_decode.sv
module cmg_addr_decode
    import cmg_pkg::*;
#(
    parameter int NUM_CORES = 6
) (
    input  logic [23:0]         addr,
    input  logic                cores_off,
    output logic                legal,
    output logic                is_imem,
    output logic [OFS_BITS-1:0] word_ofs
);
    logic [3:0]  core_num;
    logic [19:0] local_ofs;
    logic        aligned;
    logic        core_ok;
    logic        in_imem;
    logic        in_dmem;

    always_comb begin
        core_num  = addr[23:20];
        local_ofs = addr[19:0];
        aligned   = (addr[1:0] == 2'b00);
        core_ok   = (32'(core_num) < NUM_CORES);
        in_imem   = (local_ofs[19:15] == 5'b00001);
        in_dmem   = (local_ofs[19:13] == 7'b0001000);
        is_imem   = in_imem;
        legal     = aligned && core_ok && (in_dmem || (in_imem && cores_off));
        if (in_imem) begin
            word_ofs = local_ofs[14:2];
        end else begin
            word_ofs = {2'b00, local_ofs[12:2]};
        end
    end

endmodule

// File: rtl/cmg_core_mem.sv
module cmg_core_mem
    import cmg_pkg::*;
#(
    parameter int IMEM_DEPTH = 16,
    parameter int DMEM_DEPTH = 16
) (
    input  logic                clk,
    input  logic                sel,
    input  logic                wr,
    input  logic                is_imem,
    input  logic [OFS_BITS-1:0] word_ofs,
    input  logic [LANES-1:0]    lane_mask,
    input  logic [31:0]         wdata,
    output logic [31:0]         rd_word
);
    localparam int IW = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1;
    localparam int DW = (DMEM_DEPTH > 1) ? $clog2(DMEM_DEPTH) : 1;

    logic [31:0] imem [IMEM_DEPTH];
    logic [31:0] dmem [DMEM_DEPTH];
    logic [IW-1:0] i_idx;
    logic [DW-1:0] d_idx;
    logic unused_ofs_bits;

    assign i_idx = word_ofs[IW-1:0];
    assign d_idx = word_ofs[DW-1:0];
    assign unused_ofs_bits = ^word_ofs;

    always_ff @(posedge clk) begin
        if (sel) begin
            if (is_imem) begin
                rd_word <= imem[i_idx];
            end else begin
                rd_word <= dmem[d_idx];
            end
            if (wr) begin
                for (int k = 0; k < LANES; k++) begin
                    if (lane_mask[k]) begin
                        if (is_imem) begin
                            imem[i_idx][8*k +: 8] <= wdata[8*k +: 8];
                        end else begin
                            dmem[d_idx][8*k +: 8] <= wdata[8*k +: 8];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cmg_sequencer.sv
module cmg_sequencer
    import cmg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       acc_ok,
    input  logic       is_wr,
    output cmg_state_e state,
    output logic       busy,
    output logic       mem_go,
    output logic       fill_go,
    output logic       fault_go
);
    cmg_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        busy     = 1'b1;
        mem_go   = 1'b0;
        fill_go  = 1'b0;
        fault_go = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) state_nx = ST_CHECK;
            end
            ST_CHECK: begin
                state_nx = acc_ok ? ST_XFER : ST_FAULT;
            end
            ST_XFER: begin
                mem_go   = 1'b1;
                state_nx = is_wr ? ST_IDLE : ST_FILL;
            end
            ST_FILL: begin
                fill_go  = 1'b1;
                state_nx = ST_IDLE;
            end
            ST_FAULT: begin
                fault_go = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_CHECK)); // R2

    AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |=> (state == ST_IDLE)); // R2

endmodule

// File: rtl/core_mem_gateway.sv
module core_mem_gateway
    import cmg_pkg::*;
#(
    parameter int NUM_CORES  = 6,
    parameter int IMEM_DEPTH = 16,
    parameter int DMEM_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hw_en,
    input  logic [11:0] hw_addr,
    input  logic [31:0] hw_data,
    input  logic [11:0] hr_addr,
    output logic [31:0] hr_data
);
    localparam int CIW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [1:0]          core_ctl;
    logic [31:0]         wdata_q;
    logic [31:0]         rdata_q;
    logic                err_q;
    logic                cmd_wr_q;
    logic [LANES-1:0]    cmd_mask_q;
    logic [23:0]         cmd_addr_q;

    logic                start;
    logic                err_clear;
    logic                acc_ok;
    logic                is_imem;
    logic [OFS_BITS-1:0] word_ofs;
    logic [CIW-1:0]      core_idx;
    logic [NUM_CORES-1:0] core_sel;
    logic [31:0]         rd_word [NUM_CORES];
    logic [31:0]         picked;
    logic [31:0]         masked;

    cmg_state_e          state;
    logic                busy;
    logic                mem_go;
    logic                fill_go;
    logic                fault_go;
    logic                unused_host_bits;

    assign start     = hw_en && (hw_addr == OFS_CMD) && !busy;
    assign err_clear = hw_en && (hw_addr == OFS_STAT) && hw_data[1];
    assign core_idx  = cmd_addr_q[20 +: CIW];
    assign unused_host_bits = ^{hw_data[30:28], hw_data[0]};

    cmg_addr_decode #(
        .NUM_CORES (NUM_CORES)
    ) u_decode (
        .addr      (cmd_addr_q),
        .cores_off (core_ctl == CC_OFF),
        .legal     (acc_ok),
        .is_imem   (is_imem),
        .word_ofs  (word_ofs)
    );

    cmg_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .acc_ok   (acc_ok),
        .is_wr    (cmd_wr_q),
        .state    (state),
        .busy     (busy),
        .mem_go   (mem_go),
        .fill_go  (fill_go),
        .fault_go (fault_go)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign core_sel[c] = mem_go && (32'(core_idx) == c);

        cmg_core_mem #(
            .IMEM_DEPTH (IMEM_DEPTH),
            .DMEM_DEPTH (DMEM_DEPTH)
        ) u_mem (
            .clk       (clk),
            .sel       (core_sel[c]),
            .wr        (cmd_wr_q),
            .is_imem   (is_imem),
            .word_ofs  (word_ofs),
            .lane_mask (cmd_mask_q),
            .wdata     (wdata_q),
            .rd_word   (rd_word[c])
        );
    end

    always_comb begin
        picked = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (32'(core_idx) == c) picked = rd_word[c];
        end
        for (int k = 0; k < LANES; k++) begin
            masked[8*k +: 8] = cmd_mask_q[k] ? picked[8*k +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_ctl   <= CC_OFF;
            wdata_q    <= '0;
            rdata_q    <= '0;
            err_q      <= 1'b0;
            cmd_wr_q   <= 1'b0;
            cmd_mask_q <= '0;
            cmd_addr_q <= '0;
        end else begin
            if (hw_en && hw_addr == OFS_CORECTL) core_ctl <= hw_data[1:0];
            if (hw_en && hw_addr == OFS_WDATA)   wdata_q  <= hw_data;
            if (start) begin
                cmd_wr_q   <= hw_data[31];
                cmd_mask_q <= hw_data[27:24];
                cmd_addr_q <= hw_data[23:0];
            end
            if (fill_go) rdata_q <= masked;
            if (fault_go && !cmd_wr_q) rdata_q <= '0;
            if (fault_go) begin
                err_q <= 1'b1;
            end else if (err_clear) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (hr_addr)
            OFS_CORECTL: hr_data = {30'd0, core_ctl};
            OFS_WDATA:   hr_data = wdata_q;
            OFS_RDATA:   hr_data = rdata_q;
            OFS_STAT:    hr_data = {30'd0, err_q, busy};
            default:     hr_data = '0;
        endcase
    end

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_addr_q) && $stable(cmd_mask_q) && $stable(cmd_wr_q))); // R3

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_sel)); // R4

    AST_IMEM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_go && is_imem) |-> ($past(core_ctl) == CC_OFF)); // R7

    AST_ALIGNED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_go |-> (cmd_addr_q[1:0] == 2'b00)); // R8

    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_go && !cmd_wr_q) |=> (rdata_q == 32'd0)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clear) |=> err_q); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_go |=> err_q); // R9

endmodule

// File: tb/tb_core_mem_gateway.sv
`timescale 1ns/1ps
module tb_core_mem_gateway;
    import cmg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0;
    logic [11:0] hw_addr = '0;
    logic [31:0] hw_data = '0;
    logic [11:0] hr_addr = '0;
    logic [31:0] hr_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    core_mem_gateway dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_en   (hw_en),
        .hw_addr (hw_addr),
        .hw_data (hw_data),
        .hr_addr (hr_addr),
        .hr_data (hr_data)
    );

    typedef struct packed {
        logic [1:0]  ctl;
        logic [31:0] wd;
        logic [31:0] cmd;
        logic [31:0] exp;
        logic        eerr;
        logic        chk;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h11223344, 32'h8F01_0000, 32'h0,        1'b0, 1'b0}, // R4 write core0 dmem w0
        '{2'd0, 32'h0,        32'h0F01_0000, 32'h11223344, 1'b0, 1'b1}, // R4
        '{2'd0, 32'hAABBCCDD, 32'h8801_0000, 32'h0,        1'b0, 1'b0}, // R5 msb lane only
        '{2'd0, 32'h0,        32'h0F01_0000, 32'hAA223344, 1'b0, 1'b1}, // R5
        '{2'd0, 32'h0000EEFF, 32'h8301_0000, 32'h0,        1'b0, 1'b0}, // R5 low lanes
        '{2'd0, 32'h0,        32'h0601_0000, 32'h0022EE00, 1'b0, 1'b1}, // R6 middle lanes
        '{2'd0, 32'hCAFEF00D, 32'h8F50_8008, 32'h0,        1'b0, 1'b0}, // R7 core5 imem w2
        '{2'd0, 32'h0,        32'h0F50_8008, 32'hCAFEF00D, 1'b0, 1'b1}, // R7
        '{2'd1, 32'h0,        32'h0F50_8008, 32'h0,        1'b1, 1'b1}, // R7 R8 blocked read
        '{2'd2, 32'h0,        32'h8F50_8008, 32'h0,        1'b1, 1'b0}, // R7 R8 blocked write
        '{2'd0, 32'h0,        32'h0F50_8008, 32'hCAFEF00D, 1'b0, 1'b1}, // R8 unchanged
        '{2'd1, 32'h01020304, 32'h8F31_0004, 32'h0,        1'b0, 1'b0}, // R7 dmem while enabled
        '{2'd2, 32'h0,        32'h0F31_0004, 32'h01020304, 1'b0, 1'b1}, // R7
        '{2'd0, 32'h0,        32'h0F61_0000, 32'h0,        1'b1, 1'b1}, // R8 core 6
        '{2'd0, 32'h0,        32'h0F31_0006, 32'h0,        1'b1, 1'b1}, // R8 unaligned
        '{2'd0, 32'h0,        32'h0F01_2000, 32'h0,        1'b1, 1'b1}, // R8 outside window
        '{2'd0, 32'h55555555, 32'h8F11_0000, 32'h0,        1'b0, 1'b0}, // R4 core1 dmem w0
        '{2'd0, 32'h0,        32'h0F01_0000, 32'hAA22EEFF, 1'b0, 1'b1}  // R4 core0 untouched
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic host_rd(input logic [11:0] a, output logic [31:0] d);
        hr_addr = a;
        #1;
        d = hr_data;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20; i++) begin
            host_rd(OFS_STAT, s);
            if (s[0] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(input logic [31:0] cmd);
        host_wr(OFS_CMD, cmd);
        @(negedge clk);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_rd(OFS_STAT, v);    check("R1 status", v, 32'd0);
        host_rd(OFS_CORECTL, v); check("R1 corectl", v, 32'd0);
        host_rd(OFS_RDATA, v);   check("R1 rdata", v, 32'd0);

        // R10 readback
        host_wr(OFS_WDATA, 32'hDEADBEEF);
        host_rd(OFS_WDATA, v);   check("R10 wdata", v, 32'hDEADBEEF);
        host_wr(OFS_CORECTL, 32'd2);
        host_rd(OFS_CORECTL, v); check("R10 corectl", v, 32'd2);

        // vector table
        for (int i = 0; i < NV; i++) begin
            host_wr(OFS_CORECTL, {30'd0, VECS[i].ctl});
            host_wr(OFS_WDATA, VECS[i].wd);
            run_cmd(VECS[i].cmd);
            host_rd(OFS_STAT, v);
            check($sformatf("R8 error flag vec %0d", i), {31'd0, v[1]}, {31'd0, VECS[i].eerr});
            if (VECS[i].chk) begin
                host_rd(OFS_RDATA, v);
                check($sformatf("R6 rdata vec %0d", i), v, VECS[i].exp);
            end
            host_wr(OFS_STAT, 32'h2);
        end
        host_rd(OFS_STAT, v); check("R9 cleared by write", v, 32'd0);

        // R2 busy timing for a read
        host_wr(OFS_CORECTL, 32'd0);
        host_wr(OFS_CMD, 32'h0F01_0000);
        host_rd(OFS_STAT, v); check("R2 busy after cmd", {31'd0, v[0]}, 32'd1);
        @(negedge clk); @(negedge clk);
        host_rd(OFS_STAT, v); check("R2 busy in fill", {31'd0, v[0]}, 32'd1);
        @(negedge clk);
        host_rd(OFS_STAT, v); check("R2 idle by 4th edge", {31'd0, v[0]}, 32'd0);

        // R3 command while busy ignored
        host_wr(OFS_WDATA, 32'h0);
        run_cmd(32'h8F01_0010);
        host_wr(OFS_WDATA, 32'h77777777);
        host_wr(OFS_CMD, 32'h8F01_000C);
        host_wr(OFS_CMD, 32'h8F01_0010);
        @(negedge clk);
        wait_idle();
        run_cmd(32'h0F01_000C);
        host_rd(OFS_RDATA, v); check("R3 first write done", v, 32'h77777777);
        run_cmd(32'h0F01_0010);
        host_rd(OFS_RDATA, v); check("R3 busy cmd ignored", v, 32'h0);

        // R9 clear in the same cycle as a fault
        host_wr(OFS_CORECTL, 32'd1);
        host_wr(OFS_CMD, 32'h0F00_8000);
        host_wr(OFS_STAT, 32'h2);
        @(negedge clk);
        wait_idle();
        host_rd(OFS_STAT, v); check("R9 set wins over clear", {31'd0, v[1]}, 32'd1);
        host_wr(OFS_STAT, 32'h2);
        host_rd(OFS_STAT, v); check("R9 later clear", {31'd0, v[1]}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule